// File: doc/BRIEF.md
# Per-Unit Supply Rail Sequencer

This controller sits beside one arithmetic unit (an adder or a multiplier) of a data-flow datapath. The unit can be powered from any of three shared supply rails through its own header switches. The controller drives those three header enables. Every cycle it receives a requested rail index, an operation-valid flag, a sub-threshold mode flag and a policy bit. From these it decides when the rail may change and when an operation may start. It also tells the register file when to capture the unit's result.

Rail changes are asymmetric. A step toward a lower-voltage rail swaps the headers at one clock edge, and an operation may start on the new rail straight away. If the policy bit asks for power gating, all headers are instead off for one cycle. A step toward a higher-voltage rail always leaves exactly one empty settle cycle before the next operation. The unit's delay is one, two or three cycles on the high, mid and low rail. The controller holds off new work and rail moves while a multi-cycle result is still in flight. It enables the output level converter only when the unit runs below the top rail in normal mode. It flags a climb back up that comes too soon after a descent to recover the switching energy.

Top module: `unit_rail_ctrl`

## Requirements
- R1: `hdr_en` is one-hot with bit 0 = high rail (index 0), bit 1 = mid rail (index 1), bit 2 = low rail (index 2). It is all-zero only during a single gating cycle.
- R2: With `gate_on_down` low, a request for a lower rail (larger index) is accepted together with any valid operation. At the next edge the old header goes off and the new one on, with no all-off cycle, and `op_fire` shows the operation executing on the new rail.
- R3: A request for a higher rail (smaller index) holds `op_ready` low in that cycle. At the next edge the new header turns on while `op_fire` stays low for exactly that one cycle, and `op_ready` returns high in it.
- R4: With `gate_on_down` high, a downward request opens one cycle with `hdr_en` = 000 and `op_fire` low. `op_ready` is high in that cycle, and the next edge enables the requested rail.
- R5: An operation that fires in cycle E on rail index i raises `res_valid` in cycle E+i+1. `lat_cycles` equals the current rail index plus one.
- R6: After an operation fires on rail index i > 0, `busy` is high for the i cycles starting with the fire cycle. During those cycles `op_ready` is low and the rail does not move.
- R7: `lvl_conv_en` is high exactly when `subvt_mode` is low and the current rail is not the high rail.
- R8: `short_run` pulses for one cycle, the cycle after an upward request is taken, when fewer than MIN_RUN operations fired since the rail was last entered. MIN_RUN is 4 for an adder and 1 for a multiplier.
- R9: A requested rail index of 3 is ignored: the rail holds and operations proceed on it.
- R10: After reset the high rail is selected (`hdr_en` = 001), `lat_cycles` = 1, and `lvl_conv_en`, `busy`, `op_fire`, `res_valid` and `short_run` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rail | input | 2 | Requested rail index: 0 high, 1 mid, 2 low, 3 ignored |
| op_valid | input | 1 | An operation is offered this cycle |
| subvt_mode | input | 1 | Lowest rail is the sub-threshold supply; converter bypassed |
| gate_on_down | input | 1 | Downward changes pass through one all-off cycle |
| hdr_en | output | 3 | Header enables, one per rail |
| op_ready | output | 1 | The offered operation is taken at the coming edge |
| op_fire | output | 1 | An operation executes on the unit this cycle |
| busy | output | 1 | Multi-cycle result outstanding; issue and rail moves held |
| res_valid | output | 1 | Register file captures the unit's result this cycle |
| lat_cycles | output | 2 | Unit delay in cycles on the current rail |
| lvl_conv_en | output | 1 | Output level converter in the path |
| short_run | output | 1 | Upward move came before the break-even run length |

## Verification
The bench aims at the edges of rail moves. These are a downward swap that must not drop to an all-off state, an upward climb whose single settle cycle could be lost or doubled, and a gating cycle that could stretch or keep the old header lit. It also tests back-to-back operations that mix one-cycle and multi-cycle results. An off-by-one counter here would strobe `res_valid` a cycle early or late, or let an operation start while a slow result is still in flight. Other cases are an index-3 request that a naive decoder would treat as a move, and a short excursion whose run count would be missed if the counter were cleared at the wrong moment.

// File: rtl/unit_rail_pkg.sv
// Shared constants and helpers for the per-unit rail sequencer.
// Assumes rail index 0 is the fastest (highest-voltage) rail and that
// the unit's delay on rail i is i+1 clock cycles.
package unit_rail_pkg;

    localparam int DEF_NUM_RAILS = 3;

    // Index of the fastest rail; also the reset rail.
    localparam int TOP_RAIL = 0;

    // Minimum run length needed before an upward move pays off.
    function automatic int min_run_for(input bit is_mult, input int add_run, input int mul_run);
        return is_mult ? mul_run : add_run;
    endfunction

endpackage

// File: rtl/unit_rail_decide.sv
// Combinational issue/rail decision for one cycle.
// Assumes: busy blocks both issue and rail moves; a pending gated move
// overrides the live request; indices >= NUM_RAILS are not rail requests.
module unit_rail_decide #(
    parameter int NUM_RAILS = 3,
    localparam int RW = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic [RW-1:0] cur_rail,
    input  logic [RW-1:0] req_rail,
    input  logic          gating,
    input  logic [RW-1:0] pend_rail,
    input  logic          busy,
    input  logic          op_valid,
    input  logic          gate_on_down,
    output logic          ready,
    output logic          accept,
    output logic [RW-1:0] nxt_rail,
    output logic [RW-1:0] tgt_rail,
    output logic          start_gate,
    output logic          rail_up,
    output logic          rail_move
);

    logic req_ok;

    // Pick the rail the unit is heading for this cycle.
    always_comb begin
        req_ok = (32'(req_rail) < NUM_RAILS);
        if (gating)
            tgt_rail = pend_rail;
        else if (req_ok)
            tgt_rail = req_rail;
        else
            tgt_rail = cur_rail;
    end

    // Decide whether an operation is taken and where the rail goes next.
    always_comb begin
        ready      = 1'b0;
        nxt_rail   = cur_rail;
        start_gate = 1'b0;
        rail_up    = 1'b0;
        if (busy) begin
            ready = 1'b0;
        end else if (gating) begin
            ready    = 1'b1;
            nxt_rail = pend_rail;
        end else if (tgt_rail == cur_rail) begin
            ready = 1'b1;
        end else if (tgt_rail > cur_rail) begin
            if (gate_on_down) begin
                start_gate = 1'b1;
            end else begin
                ready    = 1'b1;
                nxt_rail = tgt_rail;
            end
        end else begin
            rail_up  = 1'b1;
            nxt_rail = tgt_rail;
        end
    end

    // Derived strobes for the trackers.
    always_comb begin
        accept    = ready && op_valid;
        rail_move = (nxt_rail != cur_rail) || start_gate;
    end

endmodule

// File: rtl/unit_lat_tracker.sv
// Tracks outstanding results: raises busy while a multi-cycle result
// would collide with a new issue, and strobes res_valid in the capture
// cycle. Assumes delay on rail i is i+1 and at most NUM_RAILS cycles.
module unit_lat_tracker #(
    parameter int NUM_RAILS = 3,
    localparam int RW  = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1,
    localparam int CW  = $clog2(NUM_RAILS + 1),
    localparam int SW  = NUM_RAILS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [RW-1:0] exec_rail,
    output logic          busy,
    output logic          res_valid
);

    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] dly;
    logic [SW-1:0] due;

    // Delay of the rail the accepted operation will run on.
    always_comb dly = CW'(exec_rail) + CW'(1);

    // Count the cycles during which a new issue must be held off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (accept)
            hold_cnt <= dly - CW'(1);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - CW'(1);
    end

    // Shift a marker down so that bit 0 lands in the capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            due <= '0;
        else
            due <= (due >> 1) | (accept ? (SW'(1) << dly) : SW'(0));
    end

    assign busy      = (hold_cnt != '0);
    assign res_valid = due[0];

endmodule

// File: rtl/unit_run_monitor.sv
// Counts operations fired since the rail was last entered and flags an
// upward move that comes before MIN_RUN operations have run.
// Assumes the count saturates at MIN_RUN and restarts on any move.
module unit_run_monitor #(
    parameter int MIN_RUN = 4,
    localparam int KW = $clog2(MIN_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic rail_move,
    input  logic rail_up,
    output logic short_run
);

    logic [KW-1:0] run_cnt;

    // Restart on a move, otherwise count accepted operations up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (rail_move)
            run_cnt <= accept ? KW'(1) : KW'(0);
        else if (accept && (32'(run_cnt) < MIN_RUN))
            run_cnt <= run_cnt + KW'(1);
    end

    // One-cycle flag when an upward move beats the break-even length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            short_run <= 1'b0;
        else
            short_run <= rail_up && (32'(run_cnt) < MIN_RUN);
    end

endmodule

// File: rtl/unit_rail_ctrl.sv
// Top of the per-unit supply rail sequencer. Holds the current rail, a
// one-cycle gating state, and the registered fire strobe; drives the
// header enables and the level-converter enable.
// Assumes the requester holds an offered operation until op_ready.
module unit_rail_ctrl #(
    parameter int NUM_RAILS   = unit_rail_pkg::DEF_NUM_RAILS,
    parameter bit IS_MULT     = 1'b0,
    parameter int ADD_MIN_RUN = 4,
    parameter int MUL_MIN_RUN = 1,
    localparam int RW      = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1,
    localparam int LW      = $clog2(NUM_RAILS + 1),
    localparam int MIN_RUN = unit_rail_pkg::min_run_for(IS_MULT, ADD_MIN_RUN, MUL_MIN_RUN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RW-1:0]        req_rail,
    input  logic                 op_valid,
    input  logic                 subvt_mode,
    input  logic                 gate_on_down,
    output logic [NUM_RAILS-1:0] hdr_en,
    output logic                 op_ready,
    output logic                 op_fire,
    output logic                 busy,
    output logic                 res_valid,
    output logic [LW-1:0]        lat_cycles,
    output logic                 lvl_conv_en,
    output logic                 short_run
);

    logic [RW-1:0] cur_rail;
    logic [RW-1:0] pend_rail;
    logic          gating;
    logic          accept;
    logic [RW-1:0] nxt_rail;
    logic [RW-1:0] tgt_rail;
    logic          start_gate;
    logic          rail_up;
    logic          rail_move;

    unit_rail_decide #(.NUM_RAILS(NUM_RAILS)) u_decide (
        .cur_rail     (cur_rail),
        .req_rail     (req_rail),
        .gating       (gating),
        .pend_rail    (pend_rail),
        .busy         (busy),
        .op_valid     (op_valid),
        .gate_on_down (gate_on_down),
        .ready        (op_ready),
        .accept       (accept),
        .nxt_rail     (nxt_rail),
        .tgt_rail     (tgt_rail),
        .start_gate   (start_gate),
        .rail_up      (rail_up),
        .rail_move    (rail_move)
    );

    unit_lat_tracker #(.NUM_RAILS(NUM_RAILS)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .exec_rail (nxt_rail),
        .busy      (busy),
        .res_valid (res_valid)
    );

    unit_run_monitor #(.MIN_RUN(MIN_RUN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .rail_move (rail_move),
        .rail_up   (rail_up),
        .short_run (short_run)
    );

    // Rail state: move to the decided rail, or park in the gating cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_rail  <= RW'(unit_rail_pkg::TOP_RAIL);
            pend_rail <= RW'(unit_rail_pkg::TOP_RAIL);
            gating    <= 1'b0;
        end else begin
            gating   <= start_gate;
            cur_rail <= nxt_rail;
            if (start_gate)
                pend_rail <= tgt_rail;
        end
    end

    // Fire strobe: the accepted operation executes in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_fire <= 1'b0;
        else
            op_fire <= accept;
    end

    // Header decode: one enable per rail, all off while gating.
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_hdr
        assign hdr_en[g] = !gating && (32'(cur_rail) == g);
    end

    // Latency hint and converter enable follow the current rail.
    always_comb begin
        lat_cycles  = LW'(cur_rail) + LW'(1);
        lvl_conv_en = !subvt_mode && (32'(cur_rail) != unit_rail_pkg::TOP_RAIL);
    end

endmodule

// File: rtl/unit_rail_ctrl_chk.sv
// Temporal checks on the rail sequencer's ports, attached by bind.
module unit_rail_ctrl_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 gate_on_down,
    input logic [NUM_RAILS-1:0] hdr_en,
    input logic                 op_fire,
    input logic                 res_valid
);

    // R1
    hdr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hdr_en));

    // R2
    no_gap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_on_down && hdr_en != '0) |=> hdr_en != '0);

    // R4
    gate_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_en == '0 |=> hdr_en != '0);

    // R3
    settle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hdr_en) != '0 && hdr_en != '0 && hdr_en < $past(hdr_en)) |-> !op_fire);

    // R5
    fast_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && hdr_en[0]) |=> res_valid);

    // R6
    slow_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && !hdr_en[0] && hdr_en != '0) |=> !op_fire);

endmodule

bind unit_rail_ctrl unit_rail_ctrl_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_on_down (gate_on_down),
    .hdr_en       (hdr_en),
    .op_fire      (op_fire),
    .res_valid    (res_valid)
);

// File: tb/tb_unit_rail_ctrl.sv
module tb_unit_rail_ctrl;

    localparam int MIN_RUN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_rail = 2'd0;
    logic       op_valid = 1'b0;
    logic       subvt_mode = 1'b0;
    logic       gate_on_down = 1'b0;
    logic [2:0] hdr_en;
    logic       op_ready, op_fire, busy, res_valid, lvl_conv_en, short_run;
    logic [1:0] lat_cycles;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_rail, m_pend, m_cnt, m_run;
    bit m_gate, m_fire, m_short;
    int m_due;

    always #5 clk = ~clk;

    unit_rail_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_rail(req_rail), .op_valid(op_valid),
        .subvt_mode(subvt_mode), .gate_on_down(gate_on_down), .hdr_en(hdr_en),
        .op_ready(op_ready), .op_fire(op_fire), .busy(busy), .res_valid(res_valid),
        .lat_cycles(lat_cycles), .lvl_conv_en(lvl_conv_en), .short_run(short_run)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rail = 0; m_pend = 0; m_cnt = 0; m_run = 0;
        m_gate = 0; m_fire = 0; m_short = 0; m_due = 0;
    endtask

    // Drive one cycle of inputs, compare against the reference, advance it.
    task automatic step(input int rq, input bit ov, input bit sv, input bit gd);
        int tgt, nr, d, nrun;
        bit rdy, acc, ngate, nshort;
        @(posedge clk); #2;
        req_rail = 2'(rq); op_valid = ov; subvt_mode = sv; gate_on_down = gd;
        tgt = m_gate ? m_pend : ((rq < 3) ? rq : m_rail);
        rdy = 0; nr = m_rail; ngate = 0; nshort = 0;
        if (m_cnt != 0) rdy = 0;
        else if (m_gate) begin rdy = 1; nr = m_pend; end
        else if (tgt == m_rail) rdy = 1;
        else if (tgt > m_rail) begin
            if (gd) begin ngate = 1; m_pend = tgt; end
            else begin rdy = 1; nr = tgt; end
        end else begin
            nr = tgt; nshort = (m_run < MIN_RUN);
        end
        acc = rdy && ov;
        d = nr + 1;
        #2;
        chk(hdr_en, m_gate ? 0 : (1 << m_rail), "R1 hdr_en");
        chk(op_ready, rdy, "R3 op_ready");
        chk(op_fire, m_fire, "R2 op_fire");
        chk(busy, m_cnt != 0, "R6 busy");
        chk(res_valid, m_due & 1, "R5 res_valid");
        chk(lat_cycles, m_rail + 1, "R5 lat_cycles");
        chk(lvl_conv_en, !sv && m_rail != 0, "R7 lvl_conv_en");
        chk(short_run, m_short, "R8 short_run");
        if (nr != m_rail || ngate) nrun = acc ? 1 : 0;
        else nrun = (acc && m_run < MIN_RUN) ? m_run + 1 : m_run;
        m_run = nrun;
        m_short = nshort;
        m_cnt = acc ? d - 1 : (m_cnt != 0 ? m_cnt - 1 : 0);
        m_due = (m_due >> 1) | (acc ? (1 << d) : 0);
        m_fire = acc;
        m_gate = ngate;
        m_rail = nr;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #2;
        // R10 reset state
        chk(hdr_en, 1, "R10 hdr_en");
        chk(lat_cycles, 1, "R10 lat_cycles");
        chk(lvl_conv_en, 0, "R10 lvl_conv_en");
        chk(busy, 0, "R10 busy");
        chk(op_fire | res_valid | short_run, 0, "R10 strobes");

        // downward swap with operation, then climb back too early
        step(0, 1, 0, 0);
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        chk(hdr_en, 3'b010, "R2 swapped header");
        chk(op_fire, 1, "R2 fire on new rail");
        chk(busy, 1, "R6 busy on mid");
        chk(lvl_conv_en, 1, "R7 converter on mid");
        step(1, 0, 0, 0);
        chk(busy, 0, "R6 busy released");
        step(0, 1, 0, 0);
        chk(res_valid, 1, "R5 mid result after two");
        chk(op_ready, 0, "R3 hold during climb");
        step(0, 1, 0, 0);
        chk(hdr_en, 3'b001, "R3 high header on");
        chk(op_fire, 0, "R3 settle nop");
        chk(short_run, 1, "R8 short adder excursion");
        step(3, 1, 0, 0);
        step(3, 0, 0, 0);
        chk(hdr_en, 3'b001, "R9 index 3 holds rail");
        chk(op_fire, 1, "R9 op runs on held rail");

        // gated descent to the low rail
        step(2, 1, 0, 1);
        chk(op_ready, 0, "R4 no issue at gate start");
        step(2, 1, 0, 1);
        chk(hdr_en, 3'b000, "R4 all off");
        chk(op_ready, 1, "R4 ready in gate cycle");
        step(2, 0, 0, 1);
        chk(hdr_en, 3'b100, "R4 low header on");
        chk(lat_cycles, 3, "R5 low latency");
        chk(busy, 1, "R6 busy on low");
        step(2, 0, 1, 0);
        chk(lvl_conv_en, 0, "R7 bypass in sub-threshold");
        // four ops on low, then climb: no flag
        for (int k = 0; k < 16; k++) step(2, 1, 1, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk(short_run, 0, "R8 long run not flagged");

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int rq;
            bit ov, gd, sv;
            rq = ($urandom % 8 < 6) ? m_rail : int'($urandom % 4);
            ov = ($urandom % 10) < 7;
            gd = ($urandom % 4) == 0;
            sv = ($urandom % 16) == 0;
            step(rq, ov, sv, gd);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule